// File: doc/BRIEF.md
# Shared-Pin Interrupt Controller with Line Threshold Detector

This block gathers a set of hardware event inputs into sticky flags, masks them with per-source enable bits, and drives one shared pin as an open-drain interrupt request of programmable polarity. The same pin can instead be handed to an analog call-progress path. The controller only produces the select for that path and does not model the analog output itself.

One extra flag belongs to a built-in threshold detector. Each clock it takes one of two signed line measurements, voltage or current. It forms the magnitude of that measurement and compares it with an unsigned threshold. The flag is raised once for each time the magnitude moves past the threshold in the programmed direction. Software programs the block through a small register port, polls the flags to find the cause of an interrupt, and clears the flags it has handled by writing zeros.

Top module: `irq_pin_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the configuration, enable, flag and threshold registers read 0, `pin_oe` is 0 and `aout_sel` is 1.
- R2: A high level on `src_evt[i]` at a rising clock edge sets flag bit i, whatever the enable bits hold. The bit stays set until software clears it.
- R3: A write to the flag register (address 2) clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R4: When an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: With interrupt mode on (configuration bit 0 = 1), `pin_oe` is 1 exactly when some flag and its enable bit (address 1) are both 1. `pin_out` then equals configuration bit 1 (0 = active low, 1 = active high). With interrupt mode off, `pin_oe` and `pin_out` are 0.
- R6: `aout_sel` is 1 exactly when interrupt mode is off, so the pin belongs to the analog path.
- R7: The detector uses the magnitude of the two's-complement measurement. The most negative value, -128, counts as 127.
- R8: Configuration bit 2 picks the measurement: 0 selects `meas_volt` and 1 selects `meas_curr`.
- R9: Configuration bit 3 picks the direction. 0 makes the condition "magnitude > threshold" and 1 makes it "magnitude < threshold". The threshold is the unsigned value at address 3.
- R10: The detector sets flag bit 7 only at an edge where its condition holds and did not hold at the previous edge. The condition counts as not holding before the first edge after reset.
- R11: The read port returns, by address: 0 the configuration (bits 3:0, upper bits 0), 1 the enables, 2 the flags (bit 7 is the threshold flag), and 3 the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| src_evt | input | 7 | Event inputs, one per external source |
| meas_volt | input | 8 | Signed line voltage measurement |
| meas_curr | input | 8 | Signed line current measurement |
| pin_out | output | 1 | Level the pin drives while enabled |
| pin_oe | output | 1 | Output enable of the open-drain pin |
| aout_sel | output | 1 | Pin mux select: 1 routes the analog output |

## Verification
A corrupted flag or enable bit shows at `pin_oe` at the first clock edge after it happens. The same fault shows at `reg_rdata` as soon as the flag address is read. A stuck detector history bit shows up in one of two ways: a second flag set while the magnitude stays past the threshold, or a missed crossing one edge after the measurement moves. A magnitude error shows only at the saturation point and at values next to the threshold, so the bench aims directed values there and compares every cycle of a long random run against its own model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;

  localparam logic [AW-1:0] ADDR_CFG = 2'd0;
  localparam logic [AW-1:0] ADDR_EN  = 2'd1;
  localparam logic [AW-1:0] ADDR_FLG = 2'd2;
  localparam logic [AW-1:0] ADDR_THR = 2'd3;

  localparam int unsigned CFG_BITS = 4;

  typedef struct packed {
    logic dir_below;
    logic sel_curr;
    logic pol_high;
    logic irq_mode;
  } cfg_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_thresh_det.sv
module irq_thresh_det #(
  parameter int unsigned MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] meas_a,
  input  logic [MW-1:0] meas_b,
  input  logic          sel_b,
  input  logic          dir_below,
  input  logic [MW-1:0] thr,
  output logic          cross_evt
);
  localparam logic [MW-1:0] MIN_NEG = {1'b1, {(MW-1){1'b0}}};
  localparam logic [MW-1:0] MAX_POS = {1'b0, {(MW-1){1'b1}}};

  logic [MW-1:0] sample;
  logic [MW-1:0] mag;
  logic          cond;
  logic          cond_q;
  logic          cond_d;

  always_comb begin
    sample = sel_b ? meas_b : meas_a;
    if (sample == MIN_NEG)    mag = MAX_POS;
    else if (sample[MW-1])    mag = (~sample) + {{(MW-1){1'b0}}, 1'b1};
    else                      mag = sample;
    cond      = dir_below ? (mag < thr) : (mag > thr);
    cross_evt = cond & ~cond_q;
    cond_d    = cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond_d;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags_q
);
  logic [N-1:0] flags_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      if (set_evt[i])      flags_d[i] = 1'b1;
      else if (clr_req[i]) flags_d[i] = 1'b0;
      else                 flags_d[i] = flags_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_d[i];
    end
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_pkg::*;
#(
  parameter int unsigned NF = 8,
  parameter int unsigned MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NF-1:0] flags,
  output logic [DW-1:0] rdata,
  output cfg_t          cfg_q,
  output logic [NF-1:0] en_q,
  output logic [MW-1:0] thr_q,
  output logic [NF-1:0] clr_req
);
  logic we_cfg, we_en, we_thr, we_flg;

  always_comb begin
    we_cfg  = we && (addr == ADDR_CFG);
    we_en   = we && (addr == ADDR_EN);
    we_thr  = we && (addr == ADDR_THR);
    we_flg  = we && (addr == ADDR_FLG);
    clr_req = we_flg ? ~wdata[NF-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (we_cfg) cfg_q <= cfg_t'(wdata[CFG_BITS-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (we_en) en_q <= wdata[NF-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (we_thr) thr_q <= wdata[MW-1:0];
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CFG: rdata[CFG_BITS-1:0] = cfg_q;
      ADDR_EN:  rdata[NF-1:0]       = en_q;
      ADDR_FLG: rdata[NF-1:0]       = flags;
      ADDR_THR: rdata[MW-1:0]       = thr_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 7,
  parameter int unsigned MW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [N_SRC-1:0]     src_evt,
  input  logic [MW-1:0]        meas_volt,
  input  logic [MW-1:0]        meas_curr,
  output logic                 pin_out,
  output logic                 pin_oe,
  output logic                 aout_sel
);
  localparam int unsigned NF = N_SRC + 1;

  logic          rst_n_sync;
  cfg_t          cfg_q;
  logic [NF-1:0] en_q;
  logic [MW-1:0] thr_q;
  logic [NF-1:0] clr_req;
  logic [NF-1:0] flags_q;
  logic [NF-1:0] set_evt;
  logic          thr_evt;
  logic          pend;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_reg_file #(.NF(NF), .MW(MW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .flags   (flags_q),
    .rdata   (reg_rdata),
    .cfg_q   (cfg_q),
    .en_q    (en_q),
    .thr_q   (thr_q),
    .clr_req (clr_req)
  );

  irq_thresh_det #(.MW(MW)) u_det (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .meas_a    (meas_volt),
    .meas_b    (meas_curr),
    .sel_b     (cfg_q.sel_curr),
    .dir_below (cfg_q.dir_below),
    .thr       (thr_q),
    .cross_evt (thr_evt)
  );

  assign set_evt = {thr_evt, src_evt};

  irq_flag_bank #(.N(NF)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .set_evt (set_evt),
    .clr_req (clr_req),
    .flags_q (flags_q)
  );

  always_comb begin
    pend     = |(flags_q & en_q);
    pin_oe   = cfg_q.irq_mode & pend;
    pin_out  = cfg_q.irq_mode & cfg_q.pol_high;
    aout_sel = ~cfg_q.irq_mode;
  end
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 7
) (
  input logic               clk,
  input logic               rst_n_sync,
  input logic               reg_we,
  input logic [AW-1:0]      reg_addr,
  input logic [DW-1:0]      reg_wdata,
  input logic [N_SRC-1:0]   src_evt,
  input logic [N_SRC:0]     flags_q,
  input logic [N_SRC:0]     en_q,
  input logic               irq_mode,
  input logic               thr_evt,
  input logic               pin_oe,
  input logic               aout_sel
);
  logic [N_SRC:0] clr_mask;
  logic [N_SRC:0] keep;
  logic           cfg_or_en_wr;

  always_comb begin
    clr_mask     = (reg_we && reg_addr == ADDR_FLG) ? ~reg_wdata[N_SRC:0] : '0;
    keep         = flags_q & ~clr_mask;
    cfg_or_en_wr = reg_we && (reg_addr == ADDR_CFG || reg_addr == ADDR_EN);
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n_sync)
    1'b1 |=> ((flags_q & $past(keep)) == $past(keep))); // R2

  AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    1'b1 |=> ((flags_q[N_SRC-1:0] & $past(src_evt)) == $past(src_evt))); // R4

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    1'b1 |=> ((flags_q[N_SRC-1:0] & $past(clr_mask[N_SRC-1:0] & ~src_evt)) == '0)); // R3

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (pin_oe && !cfg_or_en_wr && clr_mask == '0) |=> pin_oe); // R5

  AST_PIN_MODE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    aout_sel |-> !pin_oe); // R6

  AST_THR_EDGE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(flags_q[N_SRC]) |-> $past(thr_evt)); // R10
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .src_evt    (src_evt),
  .flags_q    (flags_q),
  .en_q       (en_q),
  .irq_mode   (cfg_q.irq_mode),
  .thr_evt    (thr_evt),
  .pin_oe     (pin_oe),
  .aout_sel   (aout_sel)
);

// File: tb/irq_pin_ctrl_tb.sv
module irq_pin_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [6:0] src_evt;
  logic [7:0] meas_volt;
  logic [7:0] meas_curr;
  logic       pin_out;
  logic       pin_oe;
  logic       aout_sel;

  int n_chk;
  int n_fail;
  bit done;

  logic [3:0] m_cfg;
  logic [7:0] m_en;
  logic [7:0] m_flg;
  logic [7:0] m_thr;
  logic       m_prev;

  irq_pin_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_evt   (src_evt),
    .meas_volt (meas_volt),
    .meas_curr (meas_curr),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .aout_sel  (aout_sel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int mag_of(input logic [7:0] x);
    int v;
    v = $signed(x);
    if (v == -128) return 127;
    if (v < 0) return -v;
    return v;
  endfunction

  function automatic bit cond_of(input logic [3:0] cfg, input logic [7:0] thr,
                                 input logic [7:0] v, input logic [7:0] c);
    int m;
    m = mag_of(cfg[2] ? c : v);
    if (cfg[3]) return m < int'(thr);
    return m > int'(thr);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] wd,
                      input logic [6:0] ev, input logic [7:0] v, input logic [7:0] c,
                      input string tag);
    bit cnd;
    logic [7:0] evall;
    logic [7:0] clr;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    src_evt = ev; meas_volt = v; meas_curr = c;
    cnd   = cond_of(m_cfg, m_thr, v, c);
    evall = {cnd && !m_prev, ev};
    clr   = (we && a == 2'd2) ? ~wd : 8'h00;
    @(posedge clk);
    m_flg  = (m_flg & ~clr) | evall;
    m_prev = cnd;
    if (we && a == 2'd0) m_cfg = wd[3:0];
    if (we && a == 2'd1) m_en  = wd;
    if (we && a == 2'd3) m_thr = wd;
    #1;
    chk("R5 pin_oe", {7'd0, pin_oe}, {7'd0, m_cfg[0] && ((m_flg & m_en) != 8'h00)});
    chk("R5 pin_out", {7'd0, pin_out}, {7'd0, m_cfg[0] & m_cfg[1]});
    chk("R6 aout_sel", {7'd0, aout_sel}, {7'd0, ~m_cfg[0]});
    reg_we = 1'b0; reg_addr = 2'd2;
    #1;
    chk(tag, reg_rdata, m_flg);
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int unused;
    n_chk = 0; n_fail = 0; done = 1'b0;
    unused = $urandom(32'd4711);
    m_cfg = '0; m_en = '0; m_flg = '0; m_thr = '0; m_prev = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    src_evt = '0; meas_volt = '0; meas_curr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pin_oe in reset", {7'd0, pin_oe}, 8'h00);
    chk("R1 aout_sel in reset", {7'd0, aout_sel}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    read_chk(2'd0, 8'h00, "R1 R11 cfg");
    read_chk(2'd1, 8'h00, "R1 R11 enable");
    read_chk(2'd2, 8'h00, "R1 R11 flags");
    read_chk(2'd3, 8'h00, "R1 R11 threshold");

    // R2: flag sets with enables off, analog mode
    step(1'b0, 2'd0, 8'h00, 7'h04, 8'h00, 8'h00, "R2 set while disabled");
    step(1'b1, 2'd0, 8'hF1, 7'h00, 8'h00, 8'h00, "R2 hold");
    read_chk(2'd0, 8'h01, "R11 cfg upper bits read 0");
    step(1'b1, 2'd1, 8'hFF, 7'h00, 8'h00, 8'h00, "R5 enabled active low");
    step(1'b1, 2'd2, 8'hFF, 7'h00, 8'h00, 8'h00, "R3 ones keep");
    step(1'b1, 2'd2, 8'hFB, 7'h00, 8'h00, 8'h00, "R3 zero clears");
    // R4: event and clear collide
    step(1'b1, 2'd2, 8'h00, 7'h02, 8'h00, 8'h00, "R4 set wins");
    step(1'b1, 2'd0, 8'h03, 7'h00, 8'h00, 8'h00, "R5 active high");
    step(1'b1, 2'd2, 8'h00, 7'h00, 8'h00, 8'h00, "R3 clear all");

    // R7 saturation: -128 vs threshold 127 then 126
    step(1'b1, 2'd3, 8'd127, 7'h00, 8'h00, 8'h00, "R7 thr 127");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h80, 8'h00, "R7 -128 not above 127");
    step(1'b1, 2'd3, 8'd126, 7'h00, 8'h80, 8'h00, "R7 thr 126");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h80, 8'h00, "R7 -128 above 126");
    // R10: hold beyond, clear, no re-trigger
    step(1'b1, 2'd2, 8'h00, 7'h00, 8'h80, 8'h00, "R10 clear while beyond");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h81, 8'h00, "R10 no retrigger");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h05, 8'h00, "R10 back inside");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h7F, 8'h00, "R10 second crossing");
    step(1'b1, 2'd2, 8'h00, 7'h00, 8'h00, 8'h00, "R10 clear");
    // R8: select current, voltage large has no effect
    step(1'b1, 2'd0, 8'h05, 7'h00, 8'h00, 8'h00, "R8 select current");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h7F, 8'h02, "R8 voltage ignored");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h00, 8'h82, "R8 current -126 not above");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h00, 8'h81, "R8 current -127 above");
    step(1'b1, 2'd2, 8'h00, 7'h00, 8'h00, 8'h00, "R8 clear");
    // R9: falling direction
    step(1'b1, 2'd3, 8'd10, 7'h00, 8'h00, 8'h00, "R9 thr 10");
    step(1'b1, 2'd0, 8'h0D, 7'h00, 8'h00, 8'h0A, "R9 below mode");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h00, 8'h0A, "R9 equal not below");
    step(1'b0, 2'd0, 8'h00, 7'h00, 8'h00, 8'hF7, "R9 -9 below");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r;
      logic       we;
      logic [1:0] a;
      logic [7:0] wd;
      r  = 8'($urandom);
      we = (r[2:0] < 3'd3);
      a  = 2'($urandom);
      wd = 8'($urandom);
      if (a == 2'd2 && r[3]) wd = wd | 8'hF0;
      if (r[7:5] == 3'd0) step(we, a, wd, 7'($urandom) & 7'($urandom), 8'h80,
                               8'($urandom), "R2 random");
      else step(we, a, wd, 7'($urandom) & 7'($urandom) & 7'($urandom),
                8'($urandom), 8'($urandom), "R2 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule